// File: doc/BRIEF.md
# Data-Processing Execute Unit with Condition Flags

This block takes one 32-bit data-processing instruction word and the operand values already read from the register file, and computes the result together with the four condition flags: negative, zero, carry and overflow. The second operand is built first. It is either an 8-bit constant rotated right by an even amount, or a register value passed through a barrel shifter. The amount for that shifter comes from the instruction or from the low byte of a third register. One of sixteen operations is then applied to the first operand and the second operand.

The surrounding pipeline evaluates the condition code and passes in the result as a single bit. It also supplies the current flags, the processor mode and the saved status word. Every output is registered, so the outputs for an instruction appear one clock after its inputs are presented. The outputs are the result, a destination write strobe with its register index, and the next value of the flags. When flags are set and the destination is the program counter, the block does not update the flags. It asks for the saved status word to be restored instead. It reports a fault when that restore is not allowed.

Top module: `dp_alu_exec`

## Requirements
- R1: The opcode is in bits [24:21], with values 0 to 15 meaning AND, EOR, SUB, RSB, ADD, ADC, SBC, RSC, TST, TEQ, CMP, CMN, ORR, MOV, BIC, MVN. Bit 25 selects the immediate operand, bit 20 is the set-flags bit S, and the destination index is in bits [15:12]. The outputs for an instruction appear one clock after its inputs are applied, and `rd_idx_o` carries the destination index.
- R2: Immediate operand: bits [7:0] are zero-extended and rotated right by 2×bits[11:8]. For logical operations, C becomes bit 31 of the rotated value when the rotation is nonzero, and keeps its input value when the rotation is zero.
- R3: Register operand with an immediate amount (bit 4 = 0): Rm is in bits [3:0], the shift type is in bits [6:5] (00 LSL, 01 LSR, 10 ASR, 11 ROR), and the amount is in bits [11:7]. An amount of 0 means: LSL leaves the value and the carry unchanged, LSR gives 0 and ASR gives the sign fill (both with carry = bit 31), and ROR rotates right by one through the carry, with carry-out = bit 0.
- R4: Register operand with a register amount (bit 4 = 1): the amount is the low byte of the Rs value. An amount of 0 leaves the value and the carry unchanged. Amounts of 32 or more give: LSL 0 with carry bit 0 at exactly 32 and carry 0 above 32; LSR 0 with carry bit 31 at exactly 32 and carry 0 above 32; ASR the sign fill with carry bit 31. ROR by a nonzero multiple of 32 leaves the value unchanged with carry bit 31.
- R5: When bit 4 = 1 and the Rm index is 15, the Rm value is increased by 4 before shifting. With bit 4 = 0 it is used unchanged.
- R6: Arithmetic operations add A + B + cin. SUB and CMP use op1, ~op2 and 1. RSB uses ~op1, op2 and 1. ADD and CMN use op1, op2 and 0. ADC uses op1, op2 and C. SBC uses op1, ~op2 and C. RSC uses ~op1, op2 and C. C becomes the carry out of the addition, so it is 1 when a subtraction does not borrow. V becomes the signed overflow.
- R7: Logical operations (AND, EOR, TST, TEQ, ORR, MOV, BIC, MVN) keep V unchanged and take C from the operand-2 carry.
- R8: When the flags are updated, N equals bit 31 of the result and Z is 1 exactly when the 32-bit result is zero. With S = 0, `flags_o` equals `flags_i`. The flag bits are ordered N, Z, C, V from bit 3 down to bit 0.
- R9: TST, TEQ, CMP and CMN never assert `rd_we_o`.
- R10: When `cond_pass_i` is 0, the instruction has no effect: no write, no restore, no fault, and `flags_o` equals `flags_i`.
- R11: When S = 1 and the destination index is 15, and no fault applies, the flags are not computed. `restore_o` is set, `restore_psr_o` carries the saved status word, and `flags_o` takes bits [31:28] of the saved word. Rd is still written by non-compare operations.
- R12: A restore request raises `fault_o` when the current mode is user (5'b10000). It also raises `fault_o` when the saved mode field [4:0] is none of 10000, 10001, 10010, 10011, 10111, 11011, 11111. A faulting instruction writes nothing, restores nothing and leaves the flags unchanged.
- R13: A synchronous active-high reset clears every output to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| instr_i | input | 32 | Data-processing instruction word |
| rn_val_i | input | 32 | First operand value |
| rm_val_i | input | 32 | Value of the register named in bits [3:0] |
| rs_val_i | input | 32 | Value of the shift-amount register |
| flags_i | input | 4 | Current flags N, Z, C, V (bit 3 to bit 0) |
| cond_pass_i | input | 1 | Condition code passed |
| mode_i | input | 5 | Current processor mode field |
| saved_psr_i | input | 32 | Saved status word for the current mode |
| result_o | output | 32 | Operation result |
| rd_we_o | output | 1 | Destination register write strobe |
| rd_idx_o | output | 4 | Destination register index |
| flags_o | output | 4 | Next flags N, Z, C, V |
| restore_o | output | 1 | Copy the saved status word into the current status word |
| restore_psr_o | output | 32 | Status word to restore, zero otherwise |
| fault_o | output | 1 | Illegal status restore |

## Verification
The operand path is tried with the value 0x80000001 under every shift type. Amounts of 0, 1, 4, exactly 32, just above 32 and 40 are used, and both amount sources are tried. This separates the special encodings of a zero amount from the register-amount cases at 32 and above. It also separates the carry taken from bit 0 from the carry taken from bit 31. The arithmetic operations are given operand pairs that borrow and that do not borrow, that overflow in the signed sense, and that wrap to zero. Carry-in is varied so that ADC, SBC and RSC differ from ADD, SUB and RSB. The logical operations run with V preset to 1, which exposes any change to V. The restore form is driven in a privileged mode, in user mode, and with an invalid saved mode. The comparison of these runs shows apart a restore, a fault and a plain write to register 15.

// File: rtl/dp_alu_pkg.sv
package dp_alu_pkg;

    localparam int WORD_W  = 32;
    localparam int SHAMT_W = $clog2(WORD_W);
    localparam logic [3:0] PC_IDX   = 4'hF;
    localparam logic [4:0] MODE_USR = 5'b10000;

    typedef enum logic [3:0] {
        OP_AND = 4'd0,  OP_EOR = 4'd1,  OP_SUB = 4'd2,  OP_RSB = 4'd3,
        OP_ADD = 4'd4,  OP_ADC = 4'd5,  OP_SBC = 4'd6,  OP_RSC = 4'd7,
        OP_TST = 4'd8,  OP_TEQ = 4'd9,  OP_CMP = 4'd10, OP_CMN = 4'd11,
        OP_ORR = 4'd12, OP_MOV = 4'd13, OP_BIC = 4'd14, OP_MVN = 4'd15
    } alu_op_e;

    typedef enum logic [1:0] {
        SH_LSL = 2'd0, SH_LSR = 2'd1, SH_ASR = 2'd2, SH_ROR = 2'd3
    } shift_e;

    typedef struct packed {
        logic n;
        logic z;
        logic c;
        logic v;
    } nzcv_t;

    typedef struct packed {
        alu_op_e    op;
        logic       imm;
        logic       s;
        logic [3:0] rd;
    } dp_fields_t;

    function automatic dp_fields_t dp_decode(input logic [25:12] w);
        dp_fields_t d;
        d.op  = alu_op_e'(w[24:21]);
        d.imm = w[25];
        d.s   = w[20];
        d.rd  = w[15:12];
        return d;
    endfunction

    function automatic logic op_is_compare(input alu_op_e op);
        return op inside {OP_TST, OP_TEQ, OP_CMP, OP_CMN};
    endfunction

    function automatic logic op_is_arith(input alu_op_e op);
        return op inside {OP_SUB, OP_RSB, OP_ADD, OP_ADC,
                          OP_SBC, OP_RSC, OP_CMP, OP_CMN};
    endfunction

    function automatic logic mode_ok(input logic [4:0] m);
        return m inside {5'b10000, 5'b10001, 5'b10010, 5'b10011,
                         5'b10111, 5'b11011, 5'b11111};
    endfunction

endpackage

// File: rtl/dpa_shifter.sv
module dpa_shifter
    import dp_alu_pkg::*;
#(
    parameter int W     = WORD_W,
    parameter int AMT_W = 8
) (
    input  logic [W-1:0]     val_i,
    input  shift_e           kind_i,
    input  logic [AMT_W-1:0] amt_i,
    input  logic             by_reg_i,
    input  logic             c_i,
    output logic [W-1:0]     val_o,
    output logic             c_o
);
    localparam int SW = $clog2(W);

    logic [SW-1:0] n;
    logic [SW-1:0] back_idx;
    logic [SW-1:0] fwd_idx;
    logic          sign;
    logic          exact;
    logic          beyond;
    logic [W-1:0]  rot_val;
    logic [W-1:0]  sra_val;

    always_comb begin
        n        = amt_i[SW-1:0];
        back_idx = ~n + 1'b1;
        fwd_idx  = n - 1'b1;
        sign     = val_i[W-1];
        exact    = (amt_i == AMT_W'(W));
        beyond   = (amt_i > AMT_W'(W));
        rot_val  = (val_i >> n) | (val_i << (W - int'(n)));
        sra_val  = W'($signed(val_i) >>> n);
        val_o    = val_i;
        c_o      = c_i;
        if (!by_reg_i) begin
            unique case (kind_i)
                SH_LSL: if (n != '0) begin
                    val_o = val_i << n;
                    c_o   = val_i[back_idx];
                end
                SH_LSR: if (n == '0) begin
                    val_o = '0;
                    c_o   = sign;
                end else begin
                    val_o = val_i >> n;
                    c_o   = val_i[fwd_idx];
                end
                SH_ASR: if (n == '0) begin
                    val_o = {W{sign}};
                    c_o   = sign;
                end else begin
                    val_o = sra_val;
                    c_o   = val_i[fwd_idx];
                end
                SH_ROR: if (n == '0) begin
                    val_o = {c_i, val_i[W-1:1]};
                    c_o   = val_i[0];
                end else begin
                    val_o = rot_val;
                    c_o   = val_i[fwd_idx];
                end
            endcase
        end else if (amt_i != '0) begin
            unique case (kind_i)
                SH_LSL: if (exact) begin
                    val_o = '0;
                    c_o   = val_i[0];
                end else if (beyond) begin
                    val_o = '0;
                    c_o   = 1'b0;
                end else begin
                    val_o = val_i << n;
                    c_o   = val_i[back_idx];
                end
                SH_LSR: if (exact) begin
                    val_o = '0;
                    c_o   = sign;
                end else if (beyond) begin
                    val_o = '0;
                    c_o   = 1'b0;
                end else begin
                    val_o = val_i >> n;
                    c_o   = val_i[fwd_idx];
                end
                SH_ASR: if (exact || beyond) begin
                    val_o = {W{sign}};
                    c_o   = sign;
                end else begin
                    val_o = sra_val;
                    c_o   = val_i[fwd_idx];
                end
                SH_ROR: if (n == '0) begin
                    val_o = val_i;
                    c_o   = sign;
                end else begin
                    val_o = rot_val;
                    c_o   = val_i[fwd_idx];
                end
            endcase
        end
    end

endmodule

// File: rtl/dpa_operand2.sv
module dpa_operand2
    import dp_alu_pkg::*;
#(
    parameter int W = WORD_W
) (
    input  logic         imm_sel_i,
    input  logic [11:0]  op2_fld_i,
    input  logic [W-1:0] rm_val_i,
    input  logic [W-1:0] rs_val_i,
    input  logic         c_i,
    output logic [W-1:0] op2_o,
    output logic         c_o
);
    localparam int SW = $clog2(W);
    localparam logic [W-1:0] PC_BIAS = W'(4);

    logic [W-1:0]  imm_base;
    logic [W-1:0]  imm_rot;
    logic [SW-1:0] rot_amt;
    logic [W-1:0]  rm_eff;
    logic [7:0]    shamt;
    logic [W-1:0]  sh_val;
    logic          sh_c;
    logic          unused_hi;

    assign unused_hi = ^rs_val_i[W-1:8];

    always_comb begin
        imm_base = W'(op2_fld_i[7:0]);
        rot_amt  = SW'({op2_fld_i[11:8], 1'b0});
        imm_rot  = (rot_amt == '0) ? imm_base
                 : ((imm_base >> rot_amt) | (imm_base << (W - int'(rot_amt))));
        rm_eff   = rm_val_i;
        if (op2_fld_i[4] && op2_fld_i[3:0] == PC_IDX) begin
            rm_eff = rm_val_i + PC_BIAS;
        end
        shamt    = op2_fld_i[4] ? rs_val_i[7:0] : {3'b000, op2_fld_i[11:7]};
    end

    dpa_shifter #(.W(W), .AMT_W(8)) shifter_i (
        .val_i   (rm_eff),
        .kind_i  (shift_e'(op2_fld_i[6:5])),
        .amt_i   (shamt),
        .by_reg_i(op2_fld_i[4]),
        .c_i     (c_i),
        .val_o   (sh_val),
        .c_o     (sh_c)
    );

    always_comb begin
        if (imm_sel_i) begin
            op2_o = imm_rot;
            c_o   = (rot_amt != '0) ? imm_rot[W-1] : c_i;
        end else begin
            op2_o = sh_val;
            c_o   = sh_c;
        end
    end

    // R2
    always_comb begin
        if (imm_sel_i && op2_fld_i[11:8] == 4'h0) begin
            imm_norot_chk: assert (op2_o == imm_base && c_o == c_i);
        end
    end

endmodule

// File: rtl/dpa_alu_core.sv
module dpa_alu_core
    import dp_alu_pkg::*;
#(
    parameter int W = WORD_W
) (
    input  alu_op_e      op_i,
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic         sh_c_i,
    input  logic         c_in_i,
    input  logic         v_in_i,
    output logic [W-1:0] res_o,
    output nzcv_t        fl_o
);
    logic [W-1:0] x;
    logic [W-1:0] y;
    logic         cin;
    logic [W:0]   sum;
    logic         arith;

    always_comb begin
        x   = a_i;
        y   = b_i;
        cin = 1'b0;
        unique case (op_i)
            OP_SUB, OP_CMP: begin y = ~b_i; cin = 1'b1;   end
            OP_RSB:         begin x = ~a_i; cin = 1'b1;   end
            OP_ADC:         begin           cin = c_in_i; end
            OP_SBC:         begin y = ~b_i; cin = c_in_i; end
            OP_RSC:         begin x = ~a_i; cin = c_in_i; end
            default: ;
        endcase
        sum = {1'b0, x} + {1'b0, y} + (W+1)'(cin);

        unique case (op_i)
            OP_AND, OP_TST: res_o = a_i & b_i;
            OP_EOR, OP_TEQ: res_o = a_i ^ b_i;
            OP_ORR:         res_o = a_i | b_i;
            OP_MOV:         res_o = b_i;
            OP_BIC:         res_o = a_i & ~b_i;
            OP_MVN:         res_o = ~b_i;
            default:        res_o = sum[W-1:0];
        endcase

        arith  = op_is_arith(op_i);
        fl_o.n = res_o[W-1];
        fl_o.z = (res_o == '0);
        fl_o.c = arith ? sum[W] : sh_c_i;
        fl_o.v = arith ? ((x[W-1] == y[W-1]) && (sum[W-1] != x[W-1])) : v_in_i;
    end

endmodule

// File: rtl/dp_alu_exec.sv
module dp_alu_exec
    import dp_alu_pkg::*;
#(
    parameter int W = WORD_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [31:0]  instr_i,
    input  logic [W-1:0] rn_val_i,
    input  logic [W-1:0] rm_val_i,
    input  logic [W-1:0] rs_val_i,
    input  logic [3:0]   flags_i,
    input  logic         cond_pass_i,
    input  logic [4:0]   mode_i,
    input  logic [31:0]  saved_psr_i,
    output logic [W-1:0] result_o,
    output logic         rd_we_o,
    output logic [3:0]   rd_idx_o,
    output logic [3:0]   flags_o,
    output logic         restore_o,
    output logic [31:0]  restore_psr_o,
    output logic         fault_o
);
    dp_fields_t   f;
    nzcv_t        fl_in;
    nzcv_t        core_fl;
    logic [W-1:0] op2;
    logic         op2_c;
    logic [W-1:0] alu_res;
    logic         restore_req;
    logic         fault_d;
    logic         live;
    logic         we_d;
    logic         restore_d;
    logic         upd_d;
    logic [3:0]   flags_d;
    logic         flag_upd_q;
    logic         unused_fields;

    assign f             = dp_decode(instr_i[25:12]);
    assign fl_in         = nzcv_t'(flags_i);
    assign unused_fields = ^{instr_i[31:26], instr_i[19:16], fl_in.n, fl_in.z};

    dpa_operand2 #(.W(W)) operand2_i (
        .imm_sel_i(f.imm),
        .op2_fld_i(instr_i[11:0]),
        .rm_val_i (rm_val_i),
        .rs_val_i (rs_val_i),
        .c_i      (fl_in.c),
        .op2_o    (op2),
        .c_o      (op2_c)
    );

    dpa_alu_core #(.W(W)) core_i (
        .op_i  (f.op),
        .a_i   (rn_val_i),
        .b_i   (op2),
        .sh_c_i(op2_c),
        .c_in_i(fl_in.c),
        .v_in_i(fl_in.v),
        .res_o (alu_res),
        .fl_o  (core_fl)
    );

    always_comb begin
        restore_req = cond_pass_i && f.s && (f.rd == PC_IDX);
        fault_d     = restore_req &&
                      ((mode_i == MODE_USR) || !mode_ok(saved_psr_i[4:0]));
        live        = cond_pass_i && !fault_d;
        we_d        = live && !op_is_compare(f.op);
        restore_d   = live && restore_req;
        upd_d       = live && f.s && !restore_req;
        flags_d     = flags_i;
        if (restore_d) begin
            flags_d = saved_psr_i[31:28];
        end else if (upd_d) begin
            flags_d = core_fl;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            result_o      <= '0;
            rd_we_o       <= 1'b0;
            rd_idx_o      <= '0;
            flags_o       <= '0;
            restore_o     <= 1'b0;
            restore_psr_o <= '0;
            fault_o       <= 1'b0;
            flag_upd_q    <= 1'b0;
        end else begin
            result_o      <= alu_res;
            rd_we_o       <= we_d;
            rd_idx_o      <= f.rd;
            flags_o       <= flags_d;
            restore_o     <= restore_d;
            restore_psr_o <= restore_d ? saved_psr_i : '0;
            fault_o       <= fault_d;
            flag_upd_q    <= upd_d;
        end
    end

    // R9
    cmp_no_write_chk: assert property (@(posedge clk) disable iff (rst)
        op_is_compare(f.op) |=> !rd_we_o);

    // R10
    skip_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !cond_pass_i |=> (!rd_we_o && !restore_o && !fault_o &&
                          flags_o == $past(flags_i)));

    // R12
    user_fault_chk: assert property (@(posedge clk) disable iff (rst)
        (cond_pass_i && f.s && f.rd == PC_IDX && mode_i == MODE_USR)
        |=> (fault_o && !rd_we_o && !restore_o));

    // R11
    restore_flags_chk: assert property (@(posedge clk) disable iff (rst)
        (cond_pass_i && f.s && f.rd == PC_IDX && mode_i != MODE_USR &&
         mode_ok(saved_psr_i[4:0]))
        |=> (restore_o && flags_o == $past(saved_psr_i[31:28])));

    // R7
    logic_keep_v_chk: assert property (@(posedge clk) disable iff (rst)
        (cond_pass_i && f.s && f.rd != PC_IDX && !op_is_arith(f.op))
        |=> (flags_o[0] == $past(flags_i[0])));

    // R8
    nz_match_chk: assert property (@(posedge clk) disable iff (rst)
        flag_upd_q |-> (flags_o[3] == result_o[W-1] &&
                        flags_o[2] == (result_o == '0)));

endmodule

// File: tb/dp_alu_exec_tb_top.sv
module dp_alu_exec_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] instr = '0, rn = '0, rm = '0, rs = '0, saved = '0;
    logic [3:0]  fl = '0;
    logic        cond = 1'b0;
    logic [4:0]  mode = 5'b10011;
    logic [31:0] result_o, restore_psr_o;
    logic        rd_we_o, restore_o, fault_o;
    logic [3:0]  rd_idx_o, flags_o;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    always #5 clk = ~clk;

    dp_alu_exec dut_i (
        .clk(clk), .rst(rst), .instr_i(instr), .rn_val_i(rn), .rm_val_i(rm),
        .rs_val_i(rs), .flags_i(fl), .cond_pass_i(cond), .mode_i(mode),
        .saved_psr_i(saved), .result_o(result_o), .rd_we_o(rd_we_o),
        .rd_idx_o(rd_idx_o), .flags_o(flags_o), .restore_o(restore_o),
        .restore_psr_o(restore_psr_o), .fault_o(fault_o)
    );

    function automatic logic [31:0] dp(input logic [3:0] op, input logic im,
                                       input logic s, input logic [3:0] rd,
                                       input logic [11:0] o2);
        return {4'hE, 2'b00, im, op, s, 4'h1, rd, o2};
    endfunction

    function automatic logic [11:0] shi(input logic [4:0] a, input logic [1:0] t,
                                        input logic [3:0] r);
        return {a, t, 1'b0, r};
    endfunction

    function automatic logic [11:0] shr(input logic [1:0] t, input logic [3:0] r);
        return {4'h3, 1'b0, t, 1'b1, r};
    endfunction

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s: actual=0x%08h expected=0x%08h", req, what, act, exp);
        end
    endtask

    task automatic drive(input logic [31:0] i, input logic [31:0] a,
                         input logic [31:0] m, input logic [31:0] s,
                         input logic [3:0] f, input logic c,
                         input logic [4:0] md, input logic [31:0] sv);
        @(negedge clk);
        instr = i; rn = a; rm = m; rs = s; fl = f; cond = c; mode = md; saved = sv;
        @(posedge clk);
        #1;
    endtask

    task automatic alu(input string req, input logic [31:0] i,
                       input logic [31:0] a, input logic [31:0] m,
                       input logic [31:0] s, input logic [3:0] f,
                       input logic [31:0] er, input logic [3:0] ef,
                       input logic ewe);
        drive(i, a, m, s, f, 1'b1, 5'b10011, 32'h13);
        chk(req, "result", result_o, er);
        chk(req, "flags", {28'h0, flags_o}, {28'h0, ef});
        chk(req, "rd_we", {31'h0, rd_we_o}, {31'h0, ewe});
    endtask

    task automatic t_reset;
        chk("R13", "result", result_o, 32'h0);
        chk("R13", "we/restore/fault", {29'h0, rd_we_o, restore_o, fault_o}, 32'h0);
        chk("R13", "flags/idx", {24'h0, flags_o, rd_idx_o}, 32'h0);
        chk("R13", "restore_psr", restore_psr_o, 32'h0);
    endtask

    task automatic t_fields;
        alu("R1", dp(4'd4, 0, 1, 4'd3, shi(5'd0, 2'd0, 4'd2)), 5, 7, 0, 4'b0000,
            32'd12, 4'b0000, 1'b1);
        chk("R1", "rd_idx", {28'h0, rd_idx_o}, 32'd3);
        alu("R1", dp(4'd13, 1, 0, 4'd9, {4'h0, 8'h5A}), 0, 0, 0, 4'b0000,
            32'h5A, 4'b0000, 1'b1);
        chk("R1", "rd_idx", {28'h0, rd_idx_o}, 32'd9);
    endtask

    task automatic t_imm;
        alu("R2", dp(4'd13, 1, 1, 4'd1, {4'h4, 8'hFF}), 0, 0, 0, 4'b0000,
            32'hFF000000, 4'b1010, 1'b1);
        alu("R2", dp(4'd13, 1, 1, 4'd1, {4'h0, 8'h00}), 0, 0, 0, 4'b0011,
            32'h0, 4'b0111, 1'b1);
        alu("R2", dp(4'd13, 1, 1, 4'd1, {4'h1, 8'h01}), 0, 0, 0, 4'b0000,
            32'h40000000, 4'b0000, 1'b1);
    endtask

    task automatic t_imm_shift;
        alu("R3", dp(4'd13, 0, 1, 4'd1, shi(5'd1, 2'd0, 4'd2)), 0, 32'h80000001, 0,
            4'b0000, 32'h2, 4'b0010, 1'b1);
        alu("R3", dp(4'd13, 0, 1, 4'd1, shi(5'd0, 2'd0, 4'd2)), 0, 32'h80000001, 0,
            4'b0010, 32'h80000001, 4'b1010, 1'b1);
        alu("R3", dp(4'd13, 0, 1, 4'd1, shi(5'd0, 2'd1, 4'd2)), 0, 32'h80000001, 0,
            4'b0000, 32'h0, 4'b0110, 1'b1);
        alu("R3", dp(4'd13, 0, 1, 4'd1, shi(5'd0, 2'd2, 4'd2)), 0, 32'h80000001, 0,
            4'b0000, 32'hFFFFFFFF, 4'b1010, 1'b1);
        alu("R3", dp(4'd13, 0, 1, 4'd1, shi(5'd0, 2'd3, 4'd2)), 0, 32'h80000001, 0,
            4'b0000, 32'h40000000, 4'b0010, 1'b1);
        alu("R3", dp(4'd13, 0, 1, 4'd1, shi(5'd4, 2'd1, 4'd2)), 0, 32'h80000008, 0,
            4'b0000, 32'h08000000, 4'b0010, 1'b1);
        alu("R3", dp(4'd13, 0, 1, 4'd1, shi(5'd4, 2'd2, 4'd2)), 0, 32'h80000000, 0,
            4'b0000, 32'hF8000000, 4'b1000, 1'b1);
    endtask

    task automatic t_reg_shift;
        alu("R4", dp(4'd13, 0, 1, 4'd1, shr(2'd0, 4'd2)), 0, 32'h80000001, 32,
            4'b0000, 32'h0, 4'b0110, 1'b1);
        alu("R4", dp(4'd13, 0, 1, 4'd1, shr(2'd0, 4'd2)), 0, 32'h80000001, 33,
            4'b0010, 32'h0, 4'b0100, 1'b1);
        alu("R4", dp(4'd13, 0, 1, 4'd1, shr(2'd1, 4'd2)), 0, 32'h80000001, 32,
            4'b0000, 32'h0, 4'b0110, 1'b1);
        alu("R4", dp(4'd13, 0, 1, 4'd1, shr(2'd2, 4'd2)), 0, 32'h80000001, 40,
            4'b0000, 32'hFFFFFFFF, 4'b1010, 1'b1);
        alu("R4", dp(4'd13, 0, 1, 4'd1, shr(2'd3, 4'd2)), 0, 32'h80000001, 32,
            4'b0000, 32'h80000001, 4'b1010, 1'b1);
        alu("R4", dp(4'd13, 0, 1, 4'd1, shr(2'd0, 4'd2)), 0, 32'h80000001, 0,
            4'b0010, 32'h80000001, 4'b1010, 1'b1);
        alu("R4", dp(4'd13, 0, 1, 4'd1, shr(2'd3, 4'd2)), 0, 32'h80000001, 4,
            4'b0000, 32'h18000000, 4'b0000, 1'b1);
        alu("R4", dp(4'd13, 0, 1, 4'd1, shr(2'd1, 4'd2)), 0, 32'h80000001, 32'h104,
            4'b0000, 32'h08000000, 4'b0000, 1'b1);
    endtask

    task automatic t_pc;
        alu("R5", dp(4'd13, 0, 0, 4'd1, shr(2'd0, 4'd15)), 0, 32'h1000, 0,
            4'b0000, 32'h1004, 4'b0000, 1'b1);
        alu("R5", dp(4'd13, 0, 0, 4'd1, shi(5'd0, 2'd0, 4'd15)), 0, 32'h1000, 0,
            4'b0000, 32'h1000, 4'b0000, 1'b1);
    endtask

    task automatic t_arith;
        alu("R6", dp(4'd2, 1, 1, 4'd1, 12'h007), 5, 0, 0, 4'b0000,
            32'hFFFFFFFE, 4'b1000, 1'b1);
        alu("R6", dp(4'd2, 1, 1, 4'd1, 12'h005), 7, 0, 0, 4'b0000,
            32'd2, 4'b0010, 1'b1);
        alu("R6", dp(4'd4, 1, 1, 4'd1, 12'h001), 32'h7FFFFFFF, 0, 0, 4'b0000,
            32'h80000000, 4'b1001, 1'b1);
        alu("R6", dp(4'd4, 1, 1, 4'd1, 12'h001), 32'hFFFFFFFF, 0, 0, 4'b0000,
            32'h0, 4'b0110, 1'b1);
        alu("R6", dp(4'd3, 1, 1, 4'd1, 12'h007), 5, 0, 0, 4'b0000,
            32'd2, 4'b0010, 1'b1);
        alu("R6", dp(4'd5, 1, 1, 4'd1, 12'h001), 1, 0, 0, 4'b0010,
            32'd3, 4'b0000, 1'b1);
        alu("R6", dp(4'd6, 1, 1, 4'd1, 12'h005), 7, 0, 0, 4'b0000,
            32'd1, 4'b0010, 1'b1);
        alu("R6", dp(4'd7, 1, 1, 4'd1, 12'h007), 5, 0, 0, 4'b0000,
            32'd1, 4'b0010, 1'b1);
    endtask

    task automatic t_logic;
        alu("R7", dp(4'd0, 0, 1, 4'd1, shi(5'd0, 2'd0, 4'd2)), 32'hF0, 32'h3C, 0,
            4'b0001, 32'h30, 4'b0001, 1'b1);
        alu("R7", dp(4'd1, 0, 1, 4'd1, shi(5'd1, 2'd0, 4'd2)), 0, 32'h80000000, 0,
            4'b0001, 32'h0, 4'b0111, 1'b1);
        alu("R7", dp(4'd14, 1, 1, 4'd1, 12'h00F), 32'hFF, 0, 0, 4'b0001,
            32'hF0, 4'b0001, 1'b1);
        alu("R7", dp(4'd12, 1, 1, 4'd1, 12'h00F), 32'hF0, 0, 0, 4'b0001,
            32'hFF, 4'b0001, 1'b1);
        alu("R8", dp(4'd15, 0, 1, 4'd1, shi(5'd0, 2'd0, 4'd2)), 0, 0, 0, 4'b0001,
            32'hFFFFFFFF, 4'b1001, 1'b1);
    endtask

    task automatic t_compare;
        alu("R9", dp(4'd10, 1, 1, 4'd3, 12'h005), 5, 0, 0, 4'b0000,
            32'h0, 4'b0110, 1'b0);
        alu("R9", dp(4'd8, 1, 1, 4'd3, 12'h00F), 32'hF0, 0, 0, 4'b0000,
            32'h0, 4'b0100, 1'b0);
        alu("R9", dp(4'd9, 1, 1, 4'd3, 12'h0FF), 32'hFF, 0, 0, 4'b0000,
            32'h0, 4'b0100, 1'b0);
        alu("R9", dp(4'd11, 1, 1, 4'd3, 12'h001), 32'hFFFFFFFF, 0, 0, 4'b0000,
            32'h0, 4'b0110, 1'b0);
    endtask

    task automatic t_noflags;
        alu("R8", dp(4'd4, 1, 0, 4'd1, 12'h001), 32'h7FFFFFFF, 0, 0, 4'b1111,
            32'h80000000, 4'b1111, 1'b1);
    endtask

    task automatic t_skip;
        drive(dp(4'd4, 1, 1, 4'd1, 12'h001), 32'hFFFFFFFF, 0, 0, 4'b0101, 1'b0,
              5'b10011, 32'h13);
        chk("R10", "we/restore/fault", {29'h0, rd_we_o, restore_o, fault_o}, 32'h0);
        chk("R10", "flags", {28'h0, flags_o}, 32'h5);
        drive(dp(4'd13, 1, 1, 4'd15, 12'h040), 0, 0, 0, 4'b0101, 1'b0,
              5'b10000, 32'h0);
        chk("R10", "restore form we/restore/fault",
            {29'h0, rd_we_o, restore_o, fault_o}, 32'h0);
    endtask

    task automatic t_restore;
        drive(dp(4'd13, 1, 1, 4'd15, 12'h040), 0, 0, 0, 4'b0101, 1'b1,
              5'b10011, 32'hA0000010);
        chk("R11", "result", result_o, 32'h40);
        chk("R11", "we/restore/fault", {29'h0, rd_we_o, restore_o, fault_o}, 32'h6);
        chk("R11", "rd_idx", {28'h0, rd_idx_o}, 32'd15);
        chk("R11", "restore_psr", restore_psr_o, 32'hA0000010);
        chk("R11", "flags", {28'h0, flags_o}, 32'hA);
        drive(dp(4'd10, 1, 1, 4'd15, 12'h001), 1, 0, 0, 4'b0000, 1'b1,
              5'b10010, 32'h6000001F);
        chk("R11", "cmp we/restore/fault", {29'h0, rd_we_o, restore_o, fault_o}, 32'h2);
        chk("R11", "cmp flags", {28'h0, flags_o}, 32'h6);
    endtask

    task automatic t_fault;
        drive(dp(4'd13, 1, 1, 4'd15, 12'h040), 0, 0, 0, 4'b0101, 1'b1,
              5'b10000, 32'hA0000013);
        chk("R12", "user we/restore/fault", {29'h0, rd_we_o, restore_o, fault_o}, 32'h1);
        chk("R12", "user flags", {28'h0, flags_o}, 32'h5);
        chk("R12", "user restore_psr", restore_psr_o, 32'h0);
        drive(dp(4'd13, 1, 1, 4'd15, 12'h040), 0, 0, 0, 4'b1001, 1'b1,
              5'b10011, 32'h00000005);
        chk("R12", "bad mode we/restore/fault", {29'h0, rd_we_o, restore_o, fault_o}, 32'h1);
        chk("R12", "bad mode flags", {28'h0, flags_o}, 32'h9);
        drive(dp(4'd13, 1, 0, 4'd15, 12'h020), 0, 0, 0, 4'b0000, 1'b1,
              5'b10000, 32'h0);
        chk("R12", "no S we/restore/fault", {29'h0, rd_we_o, restore_o, fault_o}, 32'h4);
        chk("R12", "no S result", result_o, 32'h20);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        t_reset;
        @(negedge clk);
        rst = 1'b0;
        t_fields;
        t_imm;
        t_imm_shift;
        t_reg_shift;
        t_pc;
        t_arith;
        t_logic;
        t_compare;
        t_noflags;
        t_skip;
        t_restore;
        t_fault;
        done = 1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule